// File: doc/BRIEF.md
# Exception Entry and Reset Sequencer

This block handles the control-register side of a 32-bit processor taking a reset or a translation-miss exception. Three reset requests can arrive: power-on, manual, and a reset command from the debug port. A translation-lookaside miss is raised with a flag that says whether the faulting access was a read or a write. The core supplies the faulting instruction's PC and its current status word alongside the miss.

When an event is accepted, the block updates its registers on the same clock edge: saved PC, saved status, event code, vector base and the new status word. It also drives the new fetch PC and raises a redirect strobe for one cycle. A reset sends fetch to a fixed uncached address. A translation miss sends fetch to the vector base plus a dedicated offset of 0x400, which no other exception uses. The core can load the vector base through a simple write port when no event is being taken.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_ni is low, the registers hold their power-on state: vbr_o=0, sr_o=0x700000F0, expevt_o=0x000, spc_o=0, ssr_o=0, fetch_pc_o=0xA0000000, redirect_o=0.
- R2: redirect_o is 1 for exactly the one cycle after each clock edge that accepts an event, and 0 after any edge with no request. All control registers change on that same edge. With no event and no vector-base write, every register holds its value.
- R3: On a translation miss, spc_o takes fault_pc_i and ssr_o takes cur_sr_i as sampled on the accepting edge.
- R4: A translation miss writes expevt_o=0x040 when tlb_wr_i=0 (read) and 0x060 when tlb_wr_i=1 (write).
- R5: On a translation miss, sr_o equals cur_sr_i with bits 30 (mode), 29 (register bank) and 28 (block) forced to 1. All other bits are copied unchanged.
- R6: On a translation miss, fetch_pc_o becomes the vector base held before the edge plus 0x400, modulo 2^32.
- R7: On any reset request, vbr_o becomes 0, sr_o becomes 0x700000F0 (bits 30, 29 and 28 set, interrupt-mask bits 7:4 set to 1111, all others 0), and fetch_pc_o becomes 0xA0000000. spc_o and ssr_o keep their values.
- R8: Reset requests are ranked power-on, then manual, then debug. The event code is 0x000 for power-on, 0x020 for manual and 0x000 for debug.
- R9: A reset request wins over a translation miss raised in the same cycle, and the miss is dropped.
- R10: vbr_we_i loads vbr_wdata_i into vbr_o only in a cycle with no reset or miss request. In a cycle with a request the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_req_i | input | 1 | Power-on reset request |
| man_req_i | input | 1 | Manual reset request |
| dbg_req_i | input | 1 | Debug-port reset command |
| tlb_miss_i | input | 1 | Translation miss request |
| tlb_wr_i | input | 1 | Miss was a write (1) or a read (0) |
| fault_pc_i | input | 32 | PC of the faulting instruction |
| cur_sr_i | input | 32 | Current status word |
| vbr_we_i | input | 1 | Vector base write enable |
| vbr_wdata_i | input | 32 | Vector base write data |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| fetch_pc_o | output | 32 | New fetch PC |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 32 | Saved status |
| expevt_o | output | 12 | Exception event code |
| vbr_o | output | 32 | Vector base |
| sr_o | output | 32 | Status word |

## Verification
The bench aims at the collisions. A reset arriving together with a miss must not save context or take the miss vector; a design that let the miss through would corrupt spc_o and branch off the vector base. Reset ranking is checked directly, because manual and power-on write different codes. A design that ranked them wrong would leave 0x000 where 0x020 belongs. Vector-base writes that coincide with events are checked, together with a miss taken right after a base write and a base value that overflows on the +0x400 addition. Random status words catch designs that clear, rather than keep, the untouched status bits on a miss.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned CODE_W = 12;

  localparam int unsigned SR_MD_BIT = 30;
  localparam int unsigned SR_RB_BIT = 29;
  localparam int unsigned SR_BL_BIT = 28;
  localparam int unsigned SR_IM_LO  = 4;
  localparam int unsigned SR_IM_W   = 4;

  localparam logic [CODE_W-1:0] CODE_POR    = 12'h000;
  localparam logic [CODE_W-1:0] CODE_MAN    = 12'h020;
  localparam logic [CODE_W-1:0] CODE_DBG    = 12'h000;
  localparam logic [CODE_W-1:0] CODE_TLB_RD = 12'h040;
  localparam logic [CODE_W-1:0] CODE_TLB_WR = 12'h060;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_POR    = 3'd1,
    EV_MAN    = 3'd2,
    EV_DBG    = 3'd3,
    EV_TLB_RD = 3'd4,
    EV_TLB_WR = 3'd5
  } ev_e;

  typedef struct packed {
    logic              take;
    logic              is_reset;
    logic              save_ctx;
    logic [CODE_W-1:0] code;
  } ev_ctl_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic por_i,
  input  logic man_i,
  input  logic dbg_i,
  input  logic tlb_i,
  input  logic tlb_wr_i,
  output ev_e  kind_o
);
  // fixed priority: power-on > manual > debug > translation miss
  always_comb begin
    if (por_i)      kind_o = EV_POR;
    else if (man_i) kind_o = EV_MAN;
    else if (dbg_i) kind_o = EV_DBG;
    else if (tlb_i) kind_o = tlb_wr_i ? EV_TLB_WR : EV_TLB_RD;
    else            kind_o = EV_NONE;
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
#(
  parameter int unsigned        W        = 32,
  parameter logic [W-1:0]       RESET_PC = 32'hA000_0000,
  parameter logic [W-1:0]       TLB_OFS  = 32'h0000_0400
) (
  input  ev_e          kind_i,
  input  logic [W-1:0] vbr_i,
  input  logic [W-1:0] cur_sr_i,
  output ev_ctl_t      ctl_o,
  output logic [W-1:0] tgt_pc_o,
  output logic [W-1:0] new_sr_o
);
  localparam logic [W-1:0] PRIV_MASK =
    (W'(1) << SR_MD_BIT) | (W'(1) << SR_RB_BIT) | (W'(1) << SR_BL_BIT);
  localparam logic [W-1:0] IM_MASK = W'((1 << SR_IM_W) - 1) << SR_IM_LO;
  localparam logic [W-1:0] RESET_SR = PRIV_MASK | IM_MASK;

  always_comb begin
    ctl_o    = '0;
    tgt_pc_o = RESET_PC;
    new_sr_o = RESET_SR;
    unique case (kind_i)
      EV_POR: begin
        ctl_o.take = 1'b1; ctl_o.is_reset = 1'b1; ctl_o.code = CODE_POR;
      end
      EV_MAN: begin
        ctl_o.take = 1'b1; ctl_o.is_reset = 1'b1; ctl_o.code = CODE_MAN;
      end
      EV_DBG: begin
        ctl_o.take = 1'b1; ctl_o.is_reset = 1'b1; ctl_o.code = CODE_DBG;
      end
      EV_TLB_RD, EV_TLB_WR: begin
        ctl_o.take     = 1'b1;
        ctl_o.save_ctx = 1'b1;
        ctl_o.code     = (kind_i == EV_TLB_WR) ? CODE_TLB_WR : CODE_TLB_RD;
        tgt_pc_o       = vbr_i + TLB_OFS;
        new_sr_o       = cur_sr_i | PRIV_MASK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_pkg::*;
#(
  parameter int unsigned  W        = 32,
  parameter int unsigned  CW       = 12,
  parameter logic [W-1:0] RESET_PC = 32'hA000_0000,
  parameter logic [W-1:0] RESET_SR = 32'h7000_00F0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ev_ctl_t       ctl_i,
  input  logic [W-1:0]  tgt_pc_i,
  input  logic [W-1:0]  new_sr_i,
  input  logic [W-1:0]  fault_pc_i,
  input  logic [W-1:0]  cur_sr_i,
  input  logic          vbr_we_i,
  input  logic [W-1:0]  vbr_wdata_i,
  output logic          redirect_o,
  output logic [W-1:0]  fetch_pc_o,
  output logic [W-1:0]  spc_o,
  output logic [W-1:0]  ssr_o,
  output logic [CW-1:0] expevt_o,
  output logic [W-1:0]  vbr_o,
  output logic [W-1:0]  sr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      fetch_pc_o <= RESET_PC;
      spc_o      <= '0;
      ssr_o      <= '0;
      expevt_o   <= CODE_POR;
      vbr_o      <= '0;
      sr_o       <= RESET_SR;
    end else begin
      redirect_o <= ctl_i.take;
      if (ctl_i.take) begin
        fetch_pc_o <= tgt_pc_i;
        expevt_o   <= ctl_i.code;
        sr_o       <= new_sr_i;
      end
      if (ctl_i.save_ctx) begin
        spc_o <= fault_pc_i;
        ssr_o <= cur_sr_i;
      end
      if (ctl_i.is_reset)                vbr_o <= '0;
      else if (vbr_we_i && !ctl_i.take)  vbr_o <= vbr_wdata_i;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter logic [31:0] TLB_OFS  = 32'h0000_0400
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_req_i,
  input  logic        man_req_i,
  input  logic        dbg_req_i,
  input  logic        tlb_miss_i,
  input  logic        tlb_wr_i,
  input  logic [31:0] fault_pc_i,
  input  logic [31:0] cur_sr_i,
  input  logic        vbr_we_i,
  input  logic [31:0] vbr_wdata_i,
  output logic        redirect_o,
  output logic [31:0] fetch_pc_o,
  output logic [31:0] spc_o,
  output logic [31:0] ssr_o,
  output logic [11:0] expevt_o,
  output logic [31:0] vbr_o,
  output logic [31:0] sr_o
);
  localparam logic [31:0] RESET_SR =
    (32'd1 << SR_MD_BIT) | (32'd1 << SR_RB_BIT) | (32'd1 << SR_BL_BIT) |
    (32'((1 << SR_IM_W) - 1) << SR_IM_LO);

  ev_e         kind;
  ev_ctl_t     ctl;
  logic [31:0] tgt_pc;
  logic [31:0] new_sr;

  exc_arbiter u_arb (
    .por_i    (por_req_i),
    .man_i    (man_req_i),
    .dbg_i    (dbg_req_i),
    .tlb_i    (tlb_miss_i),
    .tlb_wr_i (tlb_wr_i),
    .kind_o   (kind)
  );

  exc_vector_gen #(.W(XLEN), .RESET_PC(RESET_PC), .TLB_OFS(TLB_OFS)) u_vec (
    .kind_i   (kind),
    .vbr_i    (vbr_o),
    .cur_sr_i (cur_sr_i),
    .ctl_o    (ctl),
    .tgt_pc_o (tgt_pc),
    .new_sr_o (new_sr)
  );

  exc_ctrl_regs #(.W(XLEN), .CW(CODE_W), .RESET_PC(RESET_PC), .RESET_SR(RESET_SR)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .tgt_pc_i    (tgt_pc),
    .new_sr_i    (new_sr),
    .fault_pc_i  (fault_pc_i),
    .cur_sr_i    (cur_sr_i),
    .vbr_we_i    (vbr_we_i),
    .vbr_wdata_i (vbr_wdata_i),
    .redirect_o  (redirect_o),
    .fetch_pc_o  (fetch_pc_o),
    .spc_o       (spc_o),
    .ssr_o       (ssr_o),
    .expevt_o    (expevt_o),
    .vbr_o       (vbr_o),
    .sr_o        (sr_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        por_req_i,
  input logic        man_req_i,
  input logic        dbg_req_i,
  input logic        tlb_miss_i,
  input logic        tlb_wr_i,
  input logic [31:0] fault_pc_i,
  input logic [31:0] cur_sr_i,
  input logic        vbr_we_i,
  input logic [31:0] vbr_wdata_i,
  input logic        redirect_o,
  input logic [31:0] fetch_pc_o,
  input logic [31:0] spc_o,
  input logic [31:0] ssr_o,
  input logic [11:0] expevt_o,
  input logic [31:0] vbr_o,
  input logic [31:0] sr_o
);
  logic any_rst, any_req, tlb_only;
  assign any_rst  = por_req_i | man_req_i | dbg_req_i;
  assign any_req  = any_rst | tlb_miss_i;
  assign tlb_only = tlb_miss_i & ~any_rst;

  a_r2_strobe_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> redirect_o);
  a_r2_no_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_req |=> !redirect_o);
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_req && !vbr_we_i) |=> ($stable(spc_o) && $stable(ssr_o) && $stable(sr_o)
                                 && $stable(vbr_o) && $stable(expevt_o) && $stable(fetch_pc_o)));
  a_r3_ctx_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_only |=> (spc_o == $past(fault_pc_i) && ssr_o == $past(cur_sr_i)));
  a_r4_code_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tlb_only && !tlb_wr_i) |=> expevt_o == 12'h040);
  a_r4_code_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tlb_only && tlb_wr_i) |=> expevt_o == 12'h060);
  a_r5_sr_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_only |=> sr_o == ($past(cur_sr_i) | 32'h7000_0000));
  a_r6_tlb_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_only |=> fetch_pc_o == $past(vbr_o) + 32'h400);
  a_r7_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rst |=> (vbr_o == 32'd0 && sr_o == 32'h7000_00F0 && fetch_pc_o == 32'hA000_0000
                 && $stable(spc_o) && $stable(ssr_o)));
  a_r8_manual_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (man_req_i && !por_req_i) |=> expevt_o == 12'h020);
  a_r10_vbr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbr_we_i && !any_req) |=> vbr_o == $past(vbr_wdata_i));
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_req_i(por_req_i), .man_req_i(man_req_i),
  .dbg_req_i(dbg_req_i), .tlb_miss_i(tlb_miss_i), .tlb_wr_i(tlb_wr_i),
  .fault_pc_i(fault_pc_i), .cur_sr_i(cur_sr_i), .vbr_we_i(vbr_we_i),
  .vbr_wdata_i(vbr_wdata_i), .redirect_o(redirect_o), .fetch_pc_o(fetch_pc_o),
  .spc_o(spc_o), .ssr_o(ssr_o), .expevt_o(expevt_o), .vbr_o(vbr_o), .sr_o(sr_o)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por, man, dbg, tlb, tlb_wr, vbr_we;
  logic [31:0] fpc, csr, vbr_wd;
  logic        redirect;
  logic [31:0] fetch_pc, spc, ssr, vbr, sr;
  logic [11:0] expevt;

  int checks = 0;
  int errors = 0;

  // model state
  logic        m_red;
  logic [31:0] m_pc, m_spc, m_ssr, m_vbr, m_sr;
  logic [11:0] m_code;

  always #2.5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_req_i(por), .man_req_i(man), .dbg_req_i(dbg),
    .tlb_miss_i(tlb), .tlb_wr_i(tlb_wr), .fault_pc_i(fpc), .cur_sr_i(csr),
    .vbr_we_i(vbr_we), .vbr_wdata_i(vbr_wd), .redirect_o(redirect),
    .fetch_pc_o(fetch_pc), .spc_o(spc), .ssr_o(ssr), .expevt_o(expevt),
    .vbr_o(vbr), .sr_o(sr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] reset_code(input logic p, input logic m);
    if (p) return 12'h000;        // R8 power-on first
    else if (m) return 12'h020;
    else return 12'h000;
  endfunction

  task automatic model_step();
    logic rs;
    rs = por | man | dbg;
    m_red = rs | tlb;
    if (rs) begin                 // R7, R8, R9
      m_pc = 32'hA000_0000; m_vbr = 32'd0; m_sr = 32'h7000_00F0;
      m_code = reset_code(por, man);
    end else if (tlb) begin       // R3..R6
      m_pc = m_vbr + 32'h400;
      m_spc = fpc; m_ssr = csr;
      m_sr = csr | 32'h7000_0000;
      m_code = tlb_wr ? 12'h060 : 12'h040;
    end else if (vbr_we) begin    // R10
      m_vbr = vbr_wd;
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " R2 redirect"}, {31'd0, redirect}, {31'd0, m_red});
    chk({tag, " R6/R7 fetch_pc"}, fetch_pc, m_pc);
    chk({tag, " R3 spc"}, spc, m_spc);
    chk({tag, " R3 ssr"}, ssr, m_ssr);
    chk({tag, " R4/R8 expevt"}, {20'd0, expevt}, {20'd0, m_code});
    chk({tag, " R10 vbr"}, vbr, m_vbr);
    chk({tag, " R5/R7 sr"}, sr, m_sr);
  endtask

  task automatic drive(input logic p, input logic m, input logic d, input logic t,
                       input logic w, input logic [31:0] pc, input logic [31:0] s,
                       input logic we, input logic [31:0] wd, input string tag);
    por = p; man = m; dbg = d; tlb = t; tlb_wr = w; fpc = pc; csr = s;
    vbr_we = we; vbr_wd = wd;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    por = 0; man = 0; dbg = 0; tlb = 0; tlb_wr = 0; fpc = 0; csr = 0;
    vbr_we = 0; vbr_wd = 0;
    m_red = 0; m_pc = 32'hA000_0000; m_spc = 0; m_ssr = 0; m_vbr = 0;
    m_sr = 32'h7000_00F0; m_code = 12'h000;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // directed corners
    drive(0,0,0,0,0,0,0,1,32'h8000_1000,"R10 vbr load");
    drive(0,0,0,1,0,32'h1234_5678,32'h0000_0302,0,0,"R4 tlb read");
    drive(0,0,0,1,1,32'hCAFE_0000,32'h8000_0001,0,0,"R4 tlb write back-to-back");
    drive(0,0,0,0,0,0,0,0,0,"R2 idle after event");
    drive(0,0,0,1,0,32'h0000_0010,32'hFFFF_FFFF,1,32'h1111_1111,"R10 write during miss");
    drive(0,0,0,0,0,0,0,1,32'hFFFF_FE00,"R6 overflow base");
    drive(0,0,0,1,1,32'h0BAD_0000,32'h0000_0000,0,0,"R6 wrap target");
    drive(0,1,0,1,1,32'hDEAD_BEEF,32'h0,0,0,"R9 manual vs miss");
    drive(0,0,1,0,0,0,0,0,0,"R8 debug reset");
    drive(0,1,1,0,0,0,0,1,32'h4444_0000,"R8 manual over debug");
    drive(1,1,1,1,0,32'h5,32'h5,0,0,"R8 power-on over all");
    drive(0,0,0,0,0,0,0,1,32'h0000_2000,"R10 reload");
    drive(0,0,1,1,0,32'h77,32'h77,0,0,"R9 debug vs miss");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      drive(r < 3, (r >= 3 && r < 8) || (r == 200), (r >= 8 && r < 14) || (r == 201),
            $urandom_range(0,2) == 0, 1'($urandom), $urandom, $urandom,
            $urandom_range(0,3) == 0, $urandom, "R2 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule